// File: doc/BRIEF.md
# Two-Stage Parallel Decimal Adder

This block adds two packed decimal operands of eight digits each, with a one-bit carry-in. It returns an eight-digit decimal sum, a decimal carry-out and an overflow flag that reads the operands as ten's-complement signed numbers. When the mode input is low, the same datapath does a plain 32-bit binary add with binary carry and two's-complement overflow.

The decimal path avoids testing each digit in turn. The first stage adds six to every digit of one operand and does a single full-width binary add, so decimal carries travel along the ordinary carry chain. The carry out of each digit is recovered as the parity of the sum and both addends at the low bit of the next nibble. The second stage takes six back out of every digit that did not carry. That subtraction cannot borrow across a nibble, so all digits are corrected at the same time.

A one-cycle `start` pulse launches an operation when the block is idle. `busy` stays high while the operation runs. `done` marks the cycle in which the registered results are valid. The results stay on the outputs until the next accepted start.

Top module: `bcd_par_adder`

## Requirements
- R1: After reset, `busy`, `done`, `sum`, `cout` and `ovf` are all zero.
- R2: If `start` is sampled high at edge E0 while `busy` is low, `busy` is high after E0. `done` is high for exactly the one cycle after E1, and `busy` is low again after E2.
- R3: A `start` sampled while `busy` is high is ignored. No further `done` pulse follows, and the outputs keep the result of the running operation.
- R4: With `dec_mode`=1 and valid decimal inputs, nibble k of `sum` is decimal digit k (weight 10^k, digit 0 in bits 3:0). `sum` equals (a+b+cin) mod 10^8, and `cout` is 1 exactly when a+b+cin is at least 10^8.
- R5: Decimal carries ripple through every digit. 0x44444445+0x55555555 gives 0x00000000 with `cout`=1. 0x00000099+0x00000001 gives 0x00000100. 0x99999999+0x00000000 with cin=1 gives 0x00000000 with `cout`=1.
- R6: In decimal mode a value is negative when its top digit (bits 31:28) is 5 or more. `ovf` is 1 exactly when both operands have the same sign and the sum's sign differs from it.
- R7: With `dec_mode`=0, {`cout`,`sum`} equals the 33-bit value a+b+cin.
- R8: With `dec_mode`=0, `ovf` is 1 exactly when bit 31 of a and b agree and bit 31 of `sum` differs from them.
- R9: Once `done` has fallen, `sum`, `cout` and `ovf` stay unchanged until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch pulse, accepted only while idle |
| dec_mode | input | 1 | 1 = decimal add, 0 = binary add |
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| cin | input | 1 | Carry-in |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Results valid, one-cycle pulse |
| sum | output | 32 | Result |
| cout | output | 1 | Decimal or binary carry-out |
| ovf | output | 1 | Signed overflow for the selected mode |

## Verification
A wrong recovered digit carry in the first stage shows up in the `done` cycle. It leaves one digit that is six too large or missing its uncorrected carry, and the following digit is off by one. A mis-sequenced phase register shows up within one or two cycles as a `done` pulse that is early, late, doubled or missing, or as `busy` staying high. The ripple cases and the operands near the signed boundary (top digit 4 versus 5) each give a wrong `cout` or `ovf` in that same `done` cycle.

// File: rtl/bcd_par_adder.sv
module bcd_par_adder #(
  parameter int DIGITS = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                dec_mode,
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  input  logic                cin,
  output logic                busy,
  output logic                done,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout,
  output logic                ovf
);
  localparam int W = 4 * DIGITS;
  localparam logic [W-1:0] BIAS = {DIGITS{4'h6}};
  localparam logic [1:0] PH_IDLE = 2'd0, PH_ADD = 2'd1, PH_FIX = 2'd2;

  logic [1:0] ph;
  logic       go;

  assign go   = start && (ph == PH_IDLE);
  assign busy = (ph != PH_IDLE);
  assign done = (ph == PH_FIX);

  // stage 1: one biased full-width add
  logic [W-1:0]      b_in;
  logic [W:0]        raw;
  logic [W:0]        par;
  logic [DIGITS-1:0] dcar;
  logic              sa_in, sb_in;

  assign b_in  = dec_mode ? b + BIAS : b;
  assign raw   = {1'b0, a} + {1'b0, b_in} + {{W{1'b0}}, cin};
  assign par   = raw ^ {1'b0, a} ^ {1'b0, b_in};
  assign sa_in = dec_mode ? (a[W-1:W-4] >= 4'd5) : a[W-1];
  assign sb_in = dec_mode ? (b[W-1:W-4] >= 4'd5) : b[W-1];

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_car
      assign dcar[i] = par[4*i+4];
    end
  endgenerate

  logic [W:0]        s1_raw;
  logic [DIGITS-1:0] s1_car;
  logic              s1_dec, s1_sa, s1_sb;

  // stage 2: parallel correction, no borrow between digits
  logic [W-1:0] fixd;
  logic         rsign;

  generate
    for (genvar i = 0; i < DIGITS; i++) begin : g_fix
      assign fixd[4*i+:4] = (s1_dec && !s1_car[i]) ? s1_raw[4*i+:4] - 4'd6
                                                   : s1_raw[4*i+:4];
    end
  endgenerate

  assign rsign = s1_dec ? (fixd[W-1:W-4] >= 4'd5) : fixd[W-1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph     <= PH_IDLE;
      s1_raw <= '0;
      s1_car <= '0;
      s1_dec <= 1'b0;
      s1_sa  <= 1'b0;
      s1_sb  <= 1'b0;
      sum    <= '0;
      cout   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: if (go) ph <= PH_ADD;
        PH_ADD:  ph <= PH_FIX;
        default: ph <= PH_IDLE;
      endcase
      if (go) begin
        s1_raw <= raw;
        s1_car <= dcar;
        s1_dec <= dec_mode;
        s1_sa  <= sa_in;
        s1_sb  <= sb_in;
      end
      if (ph == PH_ADD) begin
        sum  <= fixd;
        cout <= s1_raw[W];
        ovf  <= (s1_sa == s1_sb) && (rsign != s1_sb);
      end
    end
  end

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done));
  // R2
  done_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> ##1 done);
  // R3
  done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(sum) && $stable(cout) && $stable(ovf)));
  // R5
  top_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph == PH_ADD && s1_dec) |-> (s1_car[DIGITS-1] == s1_raw[W]));
endmodule

// File: tb/sim_bcd_par_adder.sv
module sim_bcd_par_adder;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        dec_mode = 1'b0;
  logic [31:0] a = '0, b = '0;
  logic        cin = 1'b0;
  logic        busy, done, cout, ovf;
  logic [31:0] sum;
  int          errs = 0, checks = 0;
  int          cyc = 0;

  bcd_par_adder u0 (.clk(clk), .rst_n(rst_n), .start(start), .dec_mode(dec_mode),
    .a(a), .b(b), .cin(cin), .busy(busy), .done(done), .sum(sum),
    .cout(cout), .ovf(ovf));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      errs++; checks++;
      $display("FAIL watchdog: R2 actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [32:0] ref_dec(input logic [31:0] x, input logic [31:0] y, input logic c);
    logic [31:0] r = '0;
    int k = c;
    for (int i = 0; i < 8; i++) begin
      int d = x[4*i+:4] + y[4*i+:4] + k;
      k = (d >= 10) ? 1 : 0;
      r[4*i+:4] = 4'(d - 10 * k);
    end
    return {k[0], r};
  endfunction

  function automatic logic ref_ovf(input logic dm, input logic [31:0] x,
                                   input logic [31:0] y, input logic [31:0] s);
    logic sx, sy, ss;
    sx = dm ? (x[31:28] >= 5) : x[31];
    sy = dm ? (y[31:28] >= 5) : y[31];
    ss = dm ? (s[31:28] >= 5) : s[31];
    return (sx == sy) && (ss != sx);
  endfunction

  function automatic logic [31:0] rnd_bcd();
    logic [31:0] v;
    for (int i = 0; i < 8; i++) v[4*i+:4] = 4'($urandom % 10);
    return v;
  endfunction

  task automatic run(input logic dm, input logic [31:0] x, input logic [31:0] y,
                     input logic c, input string req, input bit full);
    logic [32:0] e;
    logic [63:0] eo;
    @(negedge clk);
    dec_mode = dm; a = x; b = y; cin = c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (full) chk("R2 busy", {63'd0, busy}, 64'd1);
    @(negedge clk);
    chk("R2 done", {63'd0, done}, 64'd1);
    e = dm ? ref_dec(x, y, c) : ({1'b0, x} + {1'b0, y} + {32'd0, c});
    chk(req, {31'd0, cout, sum}, {31'd0, e});
    eo = {63'd0, ref_ovf(dm, x, y, e[31:0])};
    chk(dm ? "R6 ovf" : "R8 ovf", {63'd0, ovf}, eo);
    @(negedge clk);
    if (full) chk("R2 idle", {62'd0, busy, done}, 64'd0);
  endtask

  initial begin
    logic [31:0] hs;
    void'($urandom(32'd91));
    repeat (3) @(negedge clk);
    chk("R1 reset", {29'd0, busy, done, cout, ovf}, 64'd0);
    chk("R1 sum", {32'd0, sum}, 64'd0);
    rst_n = 1'b1;

    run(1, 32'h44444445, 32'h55555555, 0, "R5 ripple", 1);
    run(1, 32'h00000099, 32'h00000001, 0, "R5 ripple", 1);
    run(1, 32'h99999999, 32'h00000000, 1, "R5 ripple", 1);
    run(1, 32'h99999999, 32'h99999999, 1, "R4 nines", 1);
    run(1, 32'h49999999, 32'h00000001, 0, "R6 boundary", 1);
    run(1, 32'h50000000, 32'h50000000, 0, "R6 boundary", 1);
    run(1, 32'h49999999, 32'h50000000, 1, "R6 boundary", 1);
    run(1, 32'h25000000, 32'h25000000, 0, "R6 boundary", 1);
    run(0, 32'h7fffffff, 32'h00000001, 0, "R7 binary", 1);
    run(0, 32'hffffffff, 32'h00000000, 1, "R7 binary", 1);
    run(0, 32'h80000000, 32'h80000000, 0, "R8 binary", 1);

    // R3: start while busy is ignored
    @(negedge clk);
    dec_mode = 1; a = 32'h00000012; b = 32'h00000034; cin = 0; start = 1;
    @(negedge clk);
    a = 32'h11111111; b = 32'h22222222; dec_mode = 0;
    @(negedge clk);
    start = 0;
    chk("R3 result", {31'd0, cout, sum}, {31'd0, 33'h000000046});
    repeat (4) begin
      @(negedge clk);
      chk("R3 no second op", {62'd0, busy, done}, 64'd0);
    end
    chk("R9 hold", {32'd0, sum}, {32'd0, 32'h00000046});

    for (int n = 0; n < 150; n++) begin
      logic dm = n[0] | n[1];
      logic [31:0] x = dm ? rnd_bcd() : $urandom;
      logic [31:0] y = dm ? rnd_bcd() : $urandom;
      run(dm, x, y, 1'($urandom), dm ? "R4 random" : "R7 random", 0);
      hs = sum;
      @(negedge clk);
      chk("R9 hold", {32'd0, sum}, {32'd0, hs});
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule